// File: doc/BRIEF.md
# Single-Cycle 16-bit Add/Subtract Processor Core

This block is a minimal processor core. It completes one instruction on every rising clock edge and has no pipeline. The program counter is a 21-bit register and is driven straight out as the instruction address. The instruction store sits outside the core. It must return the 16-bit word at that address combinationally within the same cycle. The core holds eight 16-bit general registers and a 256-byte internal data store, which is accessed as 16-bit words. It has no input path. The only way results leave the core is a 32-bit bank of output pins. Software writes these pins one 16-bit half at a time, and each pin holds its value between writes.

The arithmetic unit only adds and subtracts. A single adder serves the register arithmetic, the immediate add and the data-store address. The only conditional control transfer is a branch taken when a register holds zero. Every instruction word has the same layout: opcode in bits 15:12, rd in 11:9, rs in 8:6, rt in 5:3 and a spare field in 2:0. Immediate forms read bits 5:0 as a signed 6-bit constant. The constant-load form reads bits 7:0 as an unsigned 8-bit constant.

Top module: `tiny16_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter, all eight registers and all 32 output pins are cleared to zero. Reset is synchronous and active high.
- R2: `imem_addr` always shows the 21-bit program counter. Each rising edge out of reset executes the word on `imem_data`. Every opcode other than 6 and 7 advances the counter by one.
- R3: Opcode 0 writes rs+rt into rd. Opcode 1 writes rs−rt into rd. Both results wrap modulo 2^16.
- R4: Opcode 2 writes rs plus the sign-extended bits 5:0 into rd.
- R5: Opcode 3 writes bits 7:0, zero-extended to 16 bits, into rd. Bit 8 has no effect.
- R6: Opcode 5 stores register rd to the data store, and opcode 4 loads a word from the data store into rd. The byte address is (rs + sign-extended bits 5:0) mod 256. Bit 0 of that address is ignored, so every access is an aligned 16-bit word stored low byte first.
- R7: Opcode 6 tests register rd. If it is zero, the counter becomes its own value plus sign-extended bits 5:0. Otherwise the counter advances by one.
- R8: Opcode 7 loads the counter with bits 11:0, zero-extended to 21 bits.
- R9: Opcode 8 copies register rd to `out_pins[15:0]`, and opcode 9 copies it to `out_pins[31:16]`. Each half keeps its value until its own opcode writes it again.
- R10: Opcodes 10 to 15 change no register, no output pin and no data-store word, and they advance the counter by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 21 | Address of the instruction being executed |
| imem_data | input | 16 | Instruction word at `imem_addr`, valid in the same cycle |
| out_pins | output | 32 | Latched output pins; low and high halves written separately |

## Verification
The bench sweeps add and subtract over a grid of operand pairs and checks every one of the 64 signed immediates. These sweeps catch an adder that fails to wrap, and an immediate that is zero-extended instead of sign-extended, which would turn small negative offsets into large positive ones. The bench writes and reads back every one of the 128 data-store words, each time with a second store to the neighbouring word. A core that used address bit 0, dropped the high byte lane or mixed up the lanes would return the neighbour's value or a truncated value. It also checks that an address sum wrapping past 255 lands low in the store. The branch checks cover an untaken branch, a taken forward branch and a taken backward loop. An offset measured from the wrong base would skip or repeat an instruction and give the wrong loop total. The bench also checks that each undefined opcode leaves the pins and registers intact, and that reset zeroes registers that were loaded before it.

// File: rtl/tiny16_pkg.sv
`timescale 1ns/1ps
package tiny16_pkg;

    localparam int XLEN       = 16;
    localparam int NREGS      = 8;
    localparam int RIDX_W     = $clog2(NREGS);
    localparam int PC_W       = 21;
    localparam int DMEM_BYTES = 256;
    localparam int DADDR_W    = $clog2(DMEM_BYTES);
    localparam int LANES      = XLEN / 8;
    localparam int LANE_W     = $clog2(LANES);
    localparam int OUT_HALVES = 2;
    localparam int OUT_W      = OUT_HALVES * XLEN;
    localparam int JADDR_W    = 12;
    localparam int IMM6_W     = 6;
    localparam int IMM8_W     = 8;

    // Field positions inside an instruction word
    localparam int OPC_LSB = 12;
    localparam int OPC_W   = 4;
    localparam int RD_LSB  = 9;
    localparam int RS_LSB  = 6;
    localparam int RT_LSB  = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_ADDI  = 4'd2,
        OP_LDI   = 4'd3,
        OP_LOAD  = 4'd4,
        OP_STORE = 4'd5,
        OP_BZ    = 4'd6,
        OP_JMP   = 4'd7,
        OP_OUTLO = 4'd8,
        OP_OUTHI = 4'd9
    } opcode_e;

    typedef enum logic [1:0] {
        WB_ALU = 2'd0,
        WB_IMM = 2'd1,
        WB_MEM = 2'd2
    } wb_sel_e;

    typedef struct packed {
        logic [RIDX_W-1:0]  rd;
        logic [RIDX_W-1:0]  rs;
        logic [RIDX_W-1:0]  rt;
        logic [XLEN-1:0]    imm;
        logic [JADDR_W-1:0] jtarget;
        logic               alu_imm;
        logic               alu_sub;
        logic               reg_we;
        wb_sel_e            wb_sel;
        logic               mem_we;
        logic               br_zero;
        logic               jump;
        logic               out_lo;
        logic               out_hi;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext_imm6(input logic [IMM6_W-1:0] v);
        return {{(XLEN-IMM6_W){v[IMM6_W-1]}}, v};
    endfunction

    function automatic logic [PC_W-1:0] pc_offset(input logic [XLEN-1:0] v);
        return {{(PC_W-XLEN){v[XLEN-1]}}, v};
    endfunction

endpackage

// File: rtl/tiny16_decode.sv
`timescale 1ns/1ps
module tiny16_decode
    import tiny16_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);

    always_comb begin
        ctrl         = '0;
        ctrl.rd      = instr[RD_LSB +: RIDX_W];
        ctrl.rs      = instr[RS_LSB +: RIDX_W];
        ctrl.rt      = instr[RT_LSB +: RIDX_W];
        ctrl.imm     = sext_imm6(instr[IMM6_W-1:0]);
        ctrl.jtarget = instr[JADDR_W-1:0];
        ctrl.wb_sel  = WB_ALU;
        case (instr[OPC_LSB +: OPC_W])
            OP_ADD: begin
                ctrl.reg_we = 1'b1;
            end
            OP_SUB: begin
                ctrl.reg_we  = 1'b1;
                ctrl.alu_sub = 1'b1;
            end
            OP_ADDI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.alu_imm = 1'b1;
            end
            OP_LDI: begin
                ctrl.reg_we = 1'b1;
                ctrl.wb_sel = WB_IMM;
                ctrl.imm    = XLEN'(instr[IMM8_W-1:0]);
            end
            OP_LOAD: begin
                ctrl.reg_we  = 1'b1;
                ctrl.alu_imm = 1'b1;
                ctrl.wb_sel  = WB_MEM;
            end
            OP_STORE: begin
                ctrl.alu_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OP_BZ:    ctrl.br_zero = 1'b1;
            OP_JMP:   ctrl.jump    = 1'b1;
            OP_OUTLO: ctrl.out_lo  = 1'b1;
            OP_OUTHI: ctrl.out_hi  = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/tiny16_regfile.sv
`timescale 1ns/1ps
module tiny16_regfile #(
    parameter int W = 16,
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] waddr,
    input  logic [W-1:0]         wdata,
    input  logic [$clog2(N)-1:0] ra_a,
    input  logic [$clog2(N)-1:0] ra_b,
    input  logic [$clog2(N)-1:0] ra_c,
    output logic [W-1:0]         rd_a,
    output logic [W-1:0]         rd_b,
    output logic [W-1:0]         rd_c
);

    localparam int IDX_W = $clog2(N);

    logic [W-1:0] regs_q [N];

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                regs_q[i] <= '0;
            end else if (we && waddr == IDX_W'(i)) begin
                regs_q[i] <= wdata;
            end
        end
    end

    assign rd_a = regs_q[ra_a];
    assign rd_b = regs_q[ra_b];
    assign rd_c = regs_q[ra_c];

endmodule

// File: rtl/tiny16_alu.sv
`timescale 1ns/1ps
module tiny16_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);

    logic [W-1:0] b_eff;

    // One adder: subtraction is a + ~b + 1
    assign b_eff = sub ? ~b : b;
    assign y     = a + b_eff + W'(sub);

endmodule

// File: rtl/tiny16_dmem.sv
`timescale 1ns/1ps
module tiny16_dmem #(
    parameter int W     = 16,
    parameter int BYTES = 256
) (
    input  logic                                clk,
    input  logic                                we,
    input  logic [$clog2(BYTES/(W/8))-1:0]      widx,
    input  logic [W-1:0]                        wdata,
    output logic [W-1:0]                        rdata
);

    localparam int NLANE = W / 8;
    localparam int WORDS = BYTES / NLANE;

    // Lane l holds byte address NLANE*widx + l (low byte at lower address)
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        logic [7:0] bytes_q [WORDS];

        always_ff @(posedge clk) begin
            if (we) begin
                bytes_q[widx] <= wdata[8*l +: 8];
            end
        end

        assign rdata[8*l +: 8] = bytes_q[widx];
    end

endmodule

// File: rtl/tiny16_core.sv
`timescale 1ns/1ps
module tiny16_core
    import tiny16_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [PC_W-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    output logic [OUT_W-1:0] out_pins
);

    ctrl_t           ctrl;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_next;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] rd_val;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] mem_q;
    logic [XLEN-1:0] wb_val;
    logic            half_we [OUT_HALVES];

    assign imem_addr = pc_q;

    tiny16_decode u_dec (
        .instr (imem_data),
        .ctrl  (ctrl)
    );

    tiny16_regfile #(
        .W (XLEN),
        .N (NREGS)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (ctrl.reg_we),
        .waddr (ctrl.rd),
        .wdata (wb_val),
        .ra_a  (ctrl.rs),
        .ra_b  (ctrl.rt),
        .ra_c  (ctrl.rd),
        .rd_a  (rs_val),
        .rd_b  (rt_val),
        .rd_c  (rd_val)
    );

    assign alu_b = ctrl.alu_imm ? ctrl.imm : rt_val;

    tiny16_alu #(
        .W (XLEN)
    ) u_alu (
        .a   (rs_val),
        .b   (alu_b),
        .sub (ctrl.alu_sub),
        .y   (alu_y)
    );

    tiny16_dmem #(
        .W     (XLEN),
        .BYTES (DMEM_BYTES)
    ) u_dmem (
        .clk   (clk),
        .we    (ctrl.mem_we),
        .widx  (alu_y[DADDR_W-1:LANE_W]),
        .wdata (rd_val),
        .rdata (mem_q)
    );

    always_comb begin
        case (ctrl.wb_sel)
            WB_IMM:  wb_val = ctrl.imm;
            WB_MEM:  wb_val = mem_q;
            default: wb_val = alu_y;
        endcase
    end

    always_comb begin
        if (ctrl.jump) begin
            pc_next = PC_W'(ctrl.jtarget);
        end else if (ctrl.br_zero && rd_val == '0) begin
            pc_next = pc_q + pc_offset(ctrl.imm);
        end else begin
            pc_next = pc_q + PC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign half_we[0] = ctrl.out_lo;
    assign half_we[1] = ctrl.out_hi;

    for (genvar h = 0; h < OUT_HALVES; h++) begin : g_out
        logic [XLEN-1:0] pins_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                pins_q <= '0;
            end else if (half_we[h]) begin
                pins_q <= rd_val;
            end
        end

        assign out_pins[h*XLEN +: XLEN] = pins_q;
    end

endmodule

// File: rtl/tiny16_core_chk.sv
`timescale 1ns/1ps
module tiny16_core_chk
    import tiny16_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [PC_W-1:0]  imem_addr,
    input logic [XLEN-1:0]  imem_data,
    input logic [OUT_W-1:0] out_pins
);

    logic [OPC_W-1:0] op_w;
    logic             past_rst_q = 1'b0;

    assign op_w = imem_data[OPC_LSB +: OPC_W];

    always_ff @(posedge clk) begin
        past_rst_q <= rst;
    end

    always @(posedge clk) begin
        if (past_rst_q) begin
            AST_RESET_STATE: assert (imem_addr == '0 && out_pins == '0); // R1
        end
    end

    AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
        (op_w != OP_BZ && op_w != OP_JMP) |=> imem_addr == $past(imem_addr) + PC_W'(1)); // R2

    AST_BZ_TARGET: assert property (@(posedge clk) disable iff (rst)
        (op_w == OP_BZ) |=> (imem_addr == $past(imem_addr) + PC_W'(1)) ||
            (imem_addr == $past(imem_addr) +
                {{(PC_W-IMM6_W){$past(imem_data[IMM6_W-1])}}, $past(imem_data[IMM6_W-1:0])})); // R7

    AST_JMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (op_w == OP_JMP) |=> imem_addr == PC_W'($past(imem_data[JADDR_W-1:0]))); // R8

    AST_LO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op_w != OP_OUTLO) |=> $stable(out_pins[XLEN-1:0])); // R9

    AST_HI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op_w != OP_OUTHI) |=> $stable(out_pins[OUT_W-1:XLEN])); // R9

    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (op_w > 4'd9) |=> $stable(out_pins)); // R10

endmodule

bind tiny16_core tiny16_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .out_pins  (out_pins)
);

// File: tb/tiny16_core_tb.sv
`timescale 1ns/1ps
module tiny16_core_tb;

    localparam logic [3:0] C_ADD = 4'd0, C_SUB = 4'd1, C_ADDI = 4'd2, C_LDI = 4'd3,
                           C_LOAD = 4'd4, C_STORE = 4'd5, C_BZ = 4'd6, C_JMP = 4'd7,
                           C_OLO = 4'd8, C_OHI = 4'd9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [20:0] imem_addr;
    logic [15:0] imem_data;
    logic [31:0] out_pins;
    logic [15:0] prog [4096];
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;

    always #2.5 clk = ~clk;

    assign imem_data = prog[imem_addr[11:0]];

    tiny16_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .out_pins  (out_pins)
    );

    function automatic logic [15:0] enc_r(logic [3:0] op, int d, int s, int t);
        return {op, 3'(d), 3'(s), 3'(t), 3'b000};
    endfunction

    function automatic logic [15:0] enc_i(logic [3:0] op, int d, int s, int imm);
        return {op, 3'(d), 3'(s), 6'(imm)};
    endfunction

    function automatic logic [15:0] enc_ldi(int d, int v, bit spare);
        return {C_LDI, 3'(d), spare, 8'(v)};
    endfunction

    function automatic logic [15:0] enc_j(int a);
        return {C_JMP, 12'(a)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic new_prog();
        rst = 1'b1;
        for (int i = 0; i < 4096; i++) prog[i] = 16'h0000;
    endtask

    task automatic start();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(5ns * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1 / R2: reset state and sequential fetch over no-op words
        new_prog();
        start();
        check("R1 pins after reset", out_pins, 32'h0);
        check("R1 pc after reset", 32'(imem_addr), 32'h0);
        for (int k = 1; k <= 16; k++) begin
            step(1);
            check("R2 sequential pc", 32'(imem_addr), 32'(k));
        end

        // R3: add/sub sweep
        for (int a = 0; a < 256; a += 17) begin
            for (int b = 0; b < 256; b += 17) begin
                new_prog();
                prog[0] = enc_ldi(1, a, 1'b0);
                prog[1] = enc_ldi(2, b, 1'b0);
                prog[2] = enc_r(C_ADD, 3, 1, 2);
                prog[3] = enc_r(C_SUB, 4, 1, 2);
                prog[4] = enc_r(C_OLO, 3, 0, 0);
                prog[5] = enc_r(C_OHI, 4, 0, 0);
                prog[6] = enc_j(6);
                start();
                step(9);
                check("R3 add/sub", out_pins, {16'(a - b), 16'(a + b)});
            end
        end

        // R3: wrap at 16 bits
        new_prog();
        prog[0] = enc_ldi(1, 0, 1'b0);
        prog[1] = enc_ldi(2, 1, 1'b0);
        prog[2] = enc_r(C_SUB, 3, 1, 2);
        prog[3] = enc_r(C_ADD, 4, 3, 2);
        prog[4] = enc_r(C_OLO, 3, 0, 0);
        prog[5] = enc_r(C_OHI, 4, 0, 0);
        prog[6] = enc_j(6);
        start();
        step(9);
        check("R3 wrap", out_pins, 32'h0000_FFFF);

        // R4: every signed immediate
        for (int k = 0; k < 64; k++) begin
            int kv;
            kv = (k >= 32) ? k - 64 : k;
            new_prog();
            prog[0] = enc_ldi(1, 100, 1'b0);
            prog[1] = enc_i(C_ADDI, 2, 1, k);
            prog[2] = enc_r(C_OLO, 2, 0, 0);
            prog[3] = enc_r(C_OHI, 1, 0, 0);
            prog[4] = enc_j(4);
            start();
            step(7);
            check("R4 addi", out_pins, {16'd100, 16'(100 + kv)});
        end

        // R5: load constant over an all-ones register, spare bit toggled
        for (int v = 0; v < 256; v++) begin
            new_prog();
            prog[0] = enc_ldi(1, 0, 1'b0);
            prog[1] = enc_ldi(2, 1, 1'b0);
            prog[2] = enc_r(C_SUB, 3, 1, 2);
            prog[3] = enc_ldi(3, v, v[0]);
            prog[4] = enc_r(C_OLO, 3, 0, 0);
            prog[5] = enc_j(5);
            start();
            step(8);
            check("R5 ldi", out_pins, {16'h0, 16'(v)});
        end

        // R6: every word, neighbour written, odd offset on the load
        for (int k = 0; k < 128; k++) begin
            int v;
            v = k ^ 8'h5A;
            new_prog();
            prog[0]  = enc_ldi(1, 2 * k, 1'b0);
            prog[1]  = enc_ldi(2, v, 1'b0);
            prog[2]  = enc_i(C_STORE, 2, 1, 0);
            prog[3]  = enc_ldi(6, (2 * k + 2) & 255, 1'b0);
            prog[4]  = enc_r(C_SUB, 7, 0, 2);
            prog[5]  = enc_i(C_STORE, 7, 6, 0);
            prog[6]  = enc_i(C_LOAD, 4, 1, 1);
            prog[7]  = enc_r(C_OLO, 4, 0, 0);
            prog[8]  = enc_i(C_LOAD, 3, 6, 0);
            prog[9]  = enc_r(C_OHI, 3, 0, 0);
            prog[10] = enc_j(10);
            start();
            step(13);
            check("R6 load/store", out_pins, {16'(0 - v), 16'(v)});
        end

        // R6: address sum wraps past 255
        new_prog();
        prog[0] = enc_ldi(1, 254, 1'b0);
        prog[1] = enc_ldi(2, 8'h77, 1'b0);
        prog[2] = enc_r(C_SUB, 2, 0, 2);
        prog[3] = enc_i(C_STORE, 2, 1, 4);
        prog[4] = enc_i(C_LOAD, 3, 0, 3);
        prog[5] = enc_r(C_OLO, 3, 0, 0);
        prog[6] = enc_j(6);
        start();
        step(9);
        check("R6 address wrap", out_pins, 32'h0000_FF89);

        // R7: untaken then taken forward branch
        new_prog();
        prog[0] = enc_ldi(1, 0, 1'b0);
        prog[1] = enc_ldi(2, 5, 1'b0);
        prog[2] = enc_i(C_BZ, 2, 0, 2);
        prog[3] = enc_i(C_BZ, 1, 0, 3);
        prog[4] = enc_ldi(3, 8'hAA, 1'b0);
        prog[5] = enc_r(C_OHI, 3, 0, 0);
        prog[6] = enc_ldi(3, 8'h55, 1'b0);
        prog[7] = enc_r(C_OLO, 3, 0, 0);
        prog[8] = enc_j(8);
        start();
        step(12);
        check("R7 forward branch pins", out_pins, 32'h0000_0055);
        check("R7 forward branch pc", 32'(imem_addr), 32'd8);

        // R7: backward loop, five passes of +3
        new_prog();
        prog[0] = enc_ldi(1, 5, 1'b0);
        prog[1] = enc_ldi(2, 1, 1'b0);
        prog[2] = enc_ldi(3, 0, 1'b0);
        prog[3] = enc_i(C_ADDI, 3, 3, 3);
        prog[4] = enc_r(C_SUB, 1, 1, 2);
        prog[5] = enc_i(C_BZ, 1, 0, 2);
        prog[6] = enc_i(C_BZ, 0, 0, -3);
        prog[7] = enc_r(C_OLO, 3, 0, 0);
        prog[8] = enc_j(8);
        start();
        step(40);
        check("R7 backward loop", out_pins, 32'h0000_000F);

        // R8: absolute jumps
        new_prog();
        prog[0]      = enc_j(12'h123);
        prog[1]      = enc_ldi(1, 8'hFF, 1'b0);
        prog[2]      = enc_r(C_OLO, 1, 0, 0);
        prog[12'h123] = enc_ldi(1, 8'h3C, 1'b0);
        prog[12'h124] = enc_r(C_OHI, 1, 0, 0);
        prog[12'h125] = enc_j(12'hABC);
        prog[12'hABC] = enc_r(C_OLO, 1, 0, 0);
        prog[12'hABD] = enc_j(12'hABD);
        start();
        step(1);
        check("R8 jump pc", 32'(imem_addr), 32'h123);
        step(6);
        check("R8 jump pins", out_pins, 32'h003C_003C);
        check("R8 second jump pc", 32'(imem_addr), 32'hABD);

        // R9: halves are independent
        new_prog();
        prog[0] = enc_ldi(1, 8'h11, 1'b0);
        prog[1] = enc_r(C_OHI, 1, 0, 0);
        prog[2] = enc_ldi(2, 8'h22, 1'b0);
        prog[3] = enc_r(C_OLO, 2, 0, 0);
        prog[4] = enc_ldi(1, 8'h33, 1'b0);
        prog[5] = enc_r(C_OHI, 1, 0, 0);
        prog[6] = enc_j(6);
        start();
        step(2);
        check("R9 high half only", out_pins, 32'h0011_0000);
        step(2);
        check("R9 low half added", out_pins, 32'h0011_0022);
        step(2);
        check("R9 high rewritten, low held", out_pins, 32'h0033_0022);

        // R10: undefined opcodes are no-ops
        for (int op = 10; op < 16; op++) begin
            new_prog();
            prog[0] = enc_ldi(7, 8'h33, 1'b0);
            prog[1] = enc_r(C_OLO, 7, 0, 0);
            prog[2] = {4'(op), 12'hFFF};
            prog[3] = enc_r(C_OHI, 7, 0, 0);
            prog[4] = enc_j(4);
            start();
            step(3);
            check("R10 undefined pc", 32'(imem_addr), 32'd3);
            check("R10 undefined pins", out_pins, 32'h0000_0033);
            step(3);
            check("R10 register kept", out_pins, 32'h0033_0033);
        end

        // R1: reset clears loaded registers and pins
        new_prog();
        for (int r = 1; r < 8; r++) prog[r - 1] = enc_ldi(r, 8'h40 + r, 1'b0);
        prog[7] = enc_r(C_OLO, 1, 0, 0);
        prog[8] = enc_r(C_OHI, 7, 0, 0);
        prog[9] = enc_j(9);
        start();
        step(12);
        check("R1 setup pins", out_pins, 32'h0047_0041);
        new_prog();
        prog[0] = enc_r(C_OLO, 1, 0, 0);
        prog[1] = enc_r(C_OHI, 7, 0, 0);
        prog[2] = enc_j(2);
        start();
        check("R1 pins cleared", out_pins, 32'h0);
        step(4);
        check("R1 registers cleared", out_pins, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule